// File: doc/BRIEF.md
# Banked Bit-Addressable Scratchpad Memory

This block is the on-chip data memory of a small 8-bit controller core. It stores 128 bytes of scratchpad and serves four access paths at once. A byte port reaches any scratchpad byte either by a direct address or through a pointer register. A register-operand port reaches the eight working registers of the active bank. A bit port reads, sets or clears single bits. The low 32 bytes hold four banks of eight working registers, and a two-bit bank selector held inside the block picks which bank the register port and the pointer registers use. A 16-byte window directly above the banks can be reached one bit at a time and stays an ordinary byte range for the byte port.

Direct byte addresses and bit addresses in the upper half of the 8-bit address space do not reach the scratchpad. They go out on a side port to the special-function registers, which live outside this block. Bit set and clear on those registers is done as a read-modify-write across that side port within the same cycle. All read data leaves the block through registers. The data reflects memory contents before the clock edge on which it is captured.

Top module: `scratch_mem_unit`

## Requirements
- R1: After reset the bank selector reads 0, the byte, register and bit read outputs read 0, and with no access requested the side-port read and write strobes are low.
- R2: A byte-port access with a direct address below 0x80 reads or writes scratchpad byte `byte_addr_i`. Read data appears on `byte_rdata_o` after the next clock edge. A write and a read of one byte in the same cycle return the value held before the write.
- R3: Register `n` (`reg_idx_i`) of bank `b` is scratchpad byte 8*b + n, for reads and writes through the register port. Register read data is registered every cycle.
- R4: Writing `bank_wdata_i` with `bank_we_i` changes the active bank from the next cycle on; an access in the same cycle still uses the old bank; with `bank_we_i` low the bank holds.
- R5: With `byte_ind_i` high the byte address is taken from R0 (`byte_ptr_i`=0) or R1 (`byte_ptr_i`=1) of the active bank, and bit 7 of that pointer is ignored. An indirect access never uses the side port.
- R6: A direct byte access to 0x80 or above drives `sfr_addr_o` with that address, `sfr_we_o`/`sfr_wdata_o` for a write or `sfr_re_o` for a read, returns `sfr_rdata_i` as read data and leaves the scratchpad unchanged.
- R7: A bit address below 0x80 selects bit addr[2:0] of scratchpad byte 0x20 + addr[6:3]. `bit_op_i` encodes 0 idle, 1 read, 2 set, 3 clear; `bit_rdata_o` returns the bit's value before the operation, after the next edge.
- R8: Bit set or clear rewrites only the addressed bit of its byte in one clock cycle; the other seven bits keep their values.
- R9: A bit address of 0x80 or above selects bit addr[2:0] of the special register at addr with bits [2:0] cleared (0xAF is bit 7 of 0xA8). Set or clear drives `sfr_wdata_o` equal to `sfr_rdata_i` with only that bit changed, in the same cycle.
- R10: Bytes 0x20 to 0x2F remain readable and writable as whole bytes through the byte port, and bit operations see byte writes to them.
- R11: When several ports write the same scratchpad byte in one cycle, a bit set or clear wins over a byte write, and a byte write wins over a register write.
- R12: When a bit operation and a direct byte access both target the side port in one cycle, the side port serves the bit operation and the byte access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_we_i | input | 1 | Load the bank selector |
| bank_wdata_i | input | 2 | New bank number (high bit first) |
| bank_o | output | 2 | Active bank number |
| reg_idx_i | input | 3 | Working register index 0-7 |
| reg_we_i | input | 1 | Write the working register |
| reg_wdata_i | input | 8 | Working register write data |
| reg_rdata_o | output | 8 | Working register read data (registered) |
| byte_en_i | input | 1 | Byte port access request |
| byte_we_i | input | 1 | Byte port write (else read) |
| byte_ind_i | input | 1 | Take the address from a pointer register |
| byte_ptr_i | input | 1 | Pointer select: 0 for R0, 1 for R1 |
| byte_addr_i | input | 8 | Direct byte address |
| byte_wdata_i | input | 8 | Byte write data |
| byte_rdata_o | output | 8 | Byte read data (registered) |
| bit_op_i | input | 2 | Bit operation: 0 idle, 1 read, 2 set, 3 clear |
| bit_addr_i | input | 8 | Bit address |
| bit_rdata_o | output | 1 | Bit value before the operation (registered) |
| sfr_addr_o | output | 8 | Side-port register address |
| sfr_re_o | output | 1 | Side-port read strobe |
| sfr_we_o | output | 1 | Side-port write strobe |
| sfr_wdata_o | output | 8 | Side-port write data |
| sfr_rdata_i | input | 8 | Side-port read data (combinational from `sfr_addr_o`) |

## Verification
The scratchpad is loaded with a distinct value per byte, so a wrong address mapping shows as a wrong value and not as a lucky match. Register accesses are repeated in every bank with a bank switch in the same cycle as a read, which separates bank remapping from plain addressing and shows when the switch takes effect. Bit operations are tried at the lowest, highest and a middle bit address on both sides of 0x80, with a byte read afterwards, so an off-by-one in the byte or bit position and a write that disturbs neighbouring bits each give a different wrong byte. Same-cycle collisions between ports on one byte and on the side port show the write priority.

// File: rtl/smu_pkg.sv
// Package: shared sizes and the bit-operation encoding for the scratchpad unit.
// Assumes an 8-bit data path and a 128-byte scratchpad (half of an 8-bit space).
package smu_pkg;
    localparam int unsigned SMU_DW       = 8;
    localparam int unsigned SMU_EXT_AW   = 8;
    localparam int unsigned SMU_DEPTH    = 128;
    localparam int unsigned SMU_BANKS    = 4;
    localparam int unsigned SMU_REGS     = 8;
    localparam int unsigned SMU_BIT_BASE = 32;

    typedef enum logic [1:0] {
        BIT_IDLE = 2'd0,
        BIT_READ = 2'd1,
        BIT_SET  = 2'd2,
        BIT_CLR  = 2'd3
    } bit_op_e;
endpackage

// File: rtl/smu_bank_resolve.sv
// Module: maps a working-register index and a pointer select onto scratchpad
// byte addresses in the active bank (bank * REGS + index).
// Assumes REGS and BANKS are powers of two, so the mapping is a concatenation.
module smu_bank_resolve #(
    parameter int unsigned BANKS = smu_pkg::SMU_BANKS,
    parameter int unsigned REGS  = smu_pkg::SMU_REGS,
    parameter int unsigned AW    = 7,
    localparam int unsigned BANK_W = $clog2(BANKS),
    localparam int unsigned REG_W  = $clog2(REGS)
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [REG_W-1:0]  reg_idx_i,
    input  logic              ptr_sel_i,
    output logic [AW-1:0]     reg_addr_o,
    output logic [AW-1:0]     ptr_addr_o
);
    // Register operand address: bank number on top, register index below.
    always_comb reg_addr_o = AW'({bank_i, reg_idx_i});

    // Pointer register address: R0 or R1 of the same bank.
    always_comb ptr_addr_o = AW'({bank_i, {(REG_W-1){1'b0}}, ptr_sel_i});
endmodule

// File: rtl/smu_bit_decode.sv
// Module: splits a bit address into a target byte and a bit position.
// Lower half goes to the bit window at BIT_BASE, upper half to the register side
// port at the address with the position bits cleared.
module smu_bit_decode #(
    parameter int unsigned EXT_AW   = smu_pkg::SMU_EXT_AW,
    parameter int unsigned DW       = smu_pkg::SMU_DW,
    parameter int unsigned AW       = 7,
    parameter int unsigned BIT_BASE = smu_pkg::SMU_BIT_BASE,
    localparam int unsigned POS_W   = $clog2(DW)
) (
    input  logic [EXT_AW-1:0] bit_addr_i,
    output logic              is_sfr_o,
    output logic [AW-1:0]     ram_byte_o,
    output logic [EXT_AW-1:0] sfr_byte_o,
    output logic [POS_W-1:0]  pos_o
);
    localparam logic [AW-1:0] BASE_A = AW'(BIT_BASE);

    // Side-port selection by the top address bit.
    always_comb is_sfr_o = bit_addr_i[EXT_AW-1];

    // Bit position within the byte.
    always_comb pos_o = bit_addr_i[POS_W-1:0];

    // Window byte: base plus the byte index held above the position bits.
    always_comb ram_byte_o = BASE_A + AW'(bit_addr_i[EXT_AW-2:POS_W]);

    // Side-port byte: the address aligned down to a byte boundary of bits.
    always_comb sfr_byte_o = {bit_addr_i[EXT_AW-1:POS_W], {POS_W{1'b0}}};
endmodule

// File: rtl/smu_ram_array.sv
// Module: flop-based storage with N_RD combinational read ports and N_WR write
// ports. On a same-entry collision the lowest-numbered write port wins.
// Contents are not reset; callers initialise them.
module smu_ram_array #(
    parameter int unsigned DEPTH = smu_pkg::SMU_DEPTH,
    parameter int unsigned DW    = smu_pkg::SMU_DW,
    parameter int unsigned N_RD  = 4,
    parameter int unsigned N_WR  = 3,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_WR-1:0]              wr_en,
    input  logic [N_WR-1:0][AW-1:0]      wr_addr,
    input  logic [N_WR-1:0][DW-1:0]      wr_data,
    input  logic [N_RD-1:0][AW-1:0]      rd_addr,
    output logic [N_RD-1:0][DW-1:0]      rd_data
);
    logic [DW-1:0] cell_w [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        logic [DW-1:0] cell_q;
        logic [DW-1:0] cell_d;

        // Next value: hold, or take the highest-priority write aimed here.
        always_comb begin
            cell_d = cell_q;
            for (int p = N_WR - 1; p >= 0; p--) begin
                if (wr_en[p] && (wr_addr[p] == AW'(e))) cell_d = wr_data[p];
            end
        end

        // Storage flop for this entry.
        always_ff @(posedge clk) cell_q <= cell_d;

        assign cell_w[e] = cell_q;
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        assign rd_data[r] = cell_w[rd_addr[r]];
    end

    // Port 0 has top priority, so its write must always land (R11).
    assert_port0_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |=> (cell_w[$past(wr_addr[0])] == $past(wr_data[0])));
endmodule

// File: rtl/scratch_mem_unit.sv
// Module: top of the banked, bit-addressable scratchpad. Holds the bank
// selector, routes byte/register/bit accesses to storage or to the register
// side port, and registers all read data.
// Assumes DEPTH is half of the 2**EXT_AW space and sfr_rdata_i is combinational.
module scratch_mem_unit #(
    parameter int unsigned DW       = smu_pkg::SMU_DW,
    parameter int unsigned EXT_AW   = smu_pkg::SMU_EXT_AW,
    parameter int unsigned DEPTH    = smu_pkg::SMU_DEPTH,
    parameter int unsigned BANKS    = smu_pkg::SMU_BANKS,
    parameter int unsigned REGS     = smu_pkg::SMU_REGS,
    parameter int unsigned BIT_BASE = smu_pkg::SMU_BIT_BASE,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned BANK_W  = $clog2(BANKS),
    localparam int unsigned REG_W   = $clog2(REGS),
    localparam int unsigned POS_W   = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we_i,
    input  logic [BANK_W-1:0] bank_wdata_i,
    output logic [BANK_W-1:0] bank_o,
    input  logic [REG_W-1:0]  reg_idx_i,
    input  logic              reg_we_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    input  logic              byte_en_i,
    input  logic              byte_we_i,
    input  logic              byte_ind_i,
    input  logic              byte_ptr_i,
    input  logic [EXT_AW-1:0] byte_addr_i,
    input  logic [DW-1:0]     byte_wdata_i,
    output logic [DW-1:0]     byte_rdata_o,
    input  logic [1:0]        bit_op_i,
    input  logic [EXT_AW-1:0] bit_addr_i,
    output logic              bit_rdata_o,
    output logic [EXT_AW-1:0] sfr_addr_o,
    output logic              sfr_re_o,
    output logic              sfr_we_o,
    output logic [DW-1:0]     sfr_wdata_o,
    input  logic [DW-1:0]     sfr_rdata_i
);
    import smu_pkg::*;

    localparam int unsigned RD_BYTE = 0;
    localparam int unsigned RD_REG  = 1;
    localparam int unsigned RD_BIT  = 2;
    localparam int unsigned RD_PTR  = 3;
    localparam int unsigned WR_BIT  = 0;
    localparam int unsigned WR_BYTE = 1;
    localparam int unsigned WR_REG  = 2;

    bit_op_e                 op;
    logic [BANK_W-1:0]       bank_q;
    logic [AW-1:0]           reg_addr;
    logic [AW-1:0]           ptr_addr;
    logic                    bit_is_sfr;
    logic [AW-1:0]           bit_ram_addr;
    logic [EXT_AW-1:0]       bit_sfr_addr;
    logic [POS_W-1:0]        bit_pos;
    logic [2:0]              wr_en;
    logic [2:0][AW-1:0]      wr_addr;
    logic [2:0][DW-1:0]      wr_data;
    logic [3:0][AW-1:0]      rd_addr;
    logic [3:0][DW-1:0]      rd_data;
    logic [DW-1:0]           ptr_val;
    logic [AW-1:0]           byte_ram_addr;
    logic                    byte_is_sfr;
    logic                    bit_active;
    logic                    bit_modify;
    logic                    bit_sfr;
    logic [DW-1:0]           bit_src;
    logic [DW-1:0]           bit_mask;
    logic [DW-1:0]           bit_new;
    logic [DW-1:0]           byte_rdata_q;
    logic [DW-1:0]           reg_rdata_q;
    logic                    bit_rdata_q;
    logic                    unused_ptr_hi;

    assign op = bit_op_e'(bit_op_i);

    // Bank selector register; reset picks bank 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         bank_q <= '0;
        else if (bank_we_i) bank_q <= bank_wdata_i;
    end

    smu_bank_resolve #(.BANKS(BANKS), .REGS(REGS), .AW(AW)) u_bank (
        .bank_i     (bank_q),
        .reg_idx_i  (reg_idx_i),
        .ptr_sel_i  (byte_ptr_i),
        .reg_addr_o (reg_addr),
        .ptr_addr_o (ptr_addr)
    );

    smu_bit_decode #(.EXT_AW(EXT_AW), .DW(DW), .AW(AW), .BIT_BASE(BIT_BASE)) u_bitdec (
        .bit_addr_i (bit_addr_i),
        .is_sfr_o   (bit_is_sfr),
        .ram_byte_o (bit_ram_addr),
        .sfr_byte_o (bit_sfr_addr),
        .pos_o      (bit_pos)
    );

    // Byte-port address: pointer contents (top bit dropped) or direct address.
    always_comb begin
        ptr_val       = rd_data[RD_PTR];
        byte_ram_addr = byte_ind_i ? ptr_val[AW-1:0] : byte_addr_i[AW-1:0];
        byte_is_sfr   = byte_en_i & ~byte_ind_i & byte_addr_i[EXT_AW-1];
    end
    assign unused_ptr_hi = ^ptr_val[DW-1:AW];

    // Bit operation decode and read-modify-write value.
    always_comb begin
        bit_active = (op != BIT_IDLE);
        bit_modify = (op == BIT_SET) || (op == BIT_CLR);
        bit_sfr    = bit_active & bit_is_sfr;
        bit_src    = bit_is_sfr ? sfr_rdata_i : rd_data[RD_BIT];
        bit_mask   = DW'(1) << bit_pos;
        bit_new    = (op == BIT_SET) ? (bit_src | bit_mask) : (bit_src & ~bit_mask);
    end

    // Storage read and write port wiring; port order sets write priority.
    always_comb begin
        rd_addr[RD_BYTE] = byte_ram_addr;
        rd_addr[RD_REG]  = reg_addr;
        rd_addr[RD_BIT]  = bit_ram_addr;
        rd_addr[RD_PTR]  = ptr_addr;
        wr_en[WR_BIT]    = bit_modify & ~bit_is_sfr;
        wr_addr[WR_BIT]  = bit_ram_addr;
        wr_data[WR_BIT]  = bit_new;
        wr_en[WR_BYTE]   = byte_en_i & byte_we_i & ~byte_is_sfr;
        wr_addr[WR_BYTE] = byte_ram_addr;
        wr_data[WR_BYTE] = byte_wdata_i;
        wr_en[WR_REG]    = reg_we_i;
        wr_addr[WR_REG]  = reg_addr;
        wr_data[WR_REG]  = reg_wdata_i;
    end

    smu_ram_array #(.DEPTH(DEPTH), .DW(DW), .N_RD(4), .N_WR(3)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Side port: a bit operation owns it, otherwise a direct upper-half byte access.
    always_comb begin
        sfr_addr_o  = bit_sfr ? bit_sfr_addr : byte_addr_i;
        sfr_re_o    = bit_sfr | (byte_is_sfr & ~byte_we_i);
        sfr_we_o    = bit_sfr ? bit_modify : (byte_is_sfr & byte_we_i);
        sfr_wdata_o = bit_sfr ? bit_new : byte_wdata_i;
    end

    // Read-data registers: capture pre-edge contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_rdata_q <= '0;
            reg_rdata_q  <= '0;
            bit_rdata_q  <= 1'b0;
        end else begin
            if (byte_en_i)  byte_rdata_q <= byte_is_sfr ? sfr_rdata_i : rd_data[RD_BYTE];
            reg_rdata_q <= rd_data[RD_REG];
            if (bit_active) bit_rdata_q <= bit_src[bit_pos];
        end
    end

    assign bank_o       = bank_q;
    assign byte_rdata_o = byte_rdata_q;
    assign reg_rdata_o  = reg_rdata_q;
    assign bit_rdata_o  = bit_rdata_q;

    // Bank selector only moves on a load (R4).
    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we_i |=> $stable(bank_o));

    // Indirect byte accesses never reach the side port (R5).
    assert_ind_no_sfr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en_i && byte_ind_i && (op == BIT_IDLE)) |-> (!sfr_re_o && !sfr_we_o));

    // Direct upper-half byte access is forwarded unchanged (R6).
    assert_direct_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en_i && !byte_ind_i && byte_addr_i[EXT_AW-1] && (op == BIT_IDLE))
        |-> ((sfr_addr_o == byte_addr_i) && (sfr_we_o == byte_we_i)));

    // Side-port bit set/clear changes at most one bit of the register (R9).
    assert_sfr_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_sfr && sfr_we_o) |-> ($countones(sfr_wdata_o ^ sfr_rdata_i) <= 1));

    // Side-port writes only ever target the upper half (R6).
    assert_sfr_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we_o |-> sfr_addr_o[EXT_AW-1]);
endmodule

// File: tb/scratch_mem_unit_tb_top.sv
// Bench: directed tests, one task per scenario, each checking its own results.
module scratch_mem_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_we;
    logic [1:0] bank_wdata;
    logic [1:0] bank_q;
    logic [2:0] reg_idx;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       byte_en, byte_we, byte_ind, byte_ptr;
    logic [7:0] byte_addr, byte_wdata, byte_rdata;
    logic [1:0] bit_op;
    logic [7:0] bit_addr;
    logic       bit_rdata;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
    logic       sfr_re, sfr_we;

    logic [7:0] ram_m [128];
    logic [7:0] sfr_mem [256];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    scratch_mem_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .bank_we_i(bank_we), .bank_wdata_i(bank_wdata), .bank_o(bank_q),
        .reg_idx_i(reg_idx), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .byte_en_i(byte_en), .byte_we_i(byte_we), .byte_ind_i(byte_ind), .byte_ptr_i(byte_ptr),
        .byte_addr_i(byte_addr), .byte_wdata_i(byte_wdata), .byte_rdata_o(byte_rdata),
        .bit_op_i(bit_op), .bit_addr_i(bit_addr), .bit_rdata_o(bit_rdata),
        .sfr_addr_o(sfr_addr), .sfr_re_o(sfr_re), .sfr_we_o(sfr_we),
        .sfr_wdata_o(sfr_wdata), .sfr_rdata_i(sfr_rdata)
    );

    // Register side-port model: combinational read, write on the edge.
    assign sfr_rdata = sfr_mem[sfr_addr];
    always @(posedge clk) if (sfr_we) sfr_mem[sfr_addr] <= sfr_wdata;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        bank_we = 0; bank_wdata = 0; reg_idx = 0; reg_we = 0; reg_wdata = 0;
        byte_en = 0; byte_we = 0; byte_ind = 0; byte_ptr = 0; byte_addr = 0; byte_wdata = 0;
        bit_op = 0; bit_addr = 0;
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        byte_en = 1; byte_we = 1; byte_addr = a; byte_wdata = d;
        cyc(); idle();
    endtask

    task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
        byte_en = 1; byte_addr = a;
        cyc(); d = byte_rdata; idle();
    endtask

    task automatic set_bank(input logic [1:0] b);
        bank_we = 1; bank_wdata = b;
        cyc(); idle();
    endtask

    task automatic bit_do(input logic [1:0] o, input logic [7:0] a, output logic v);
        bit_op = o; bit_addr = a;
        cyc(); v = bit_rdata; idle();
    endtask

    task automatic t_reset();
        check("R1", "bank after reset", 32'(bank_q), 0);
        check("R1", "byte rdata after reset", 32'(byte_rdata), 0);
        check("R1", "reg rdata after reset", 32'(reg_rdata), 0);
        check("R1", "bit rdata after reset", 32'(bit_rdata), 0);
        check("R1", "side strobes idle", 32'({sfr_re, sfr_we}), 0);
    endtask

    task automatic t_init();
        for (int a = 0; a < 128; a++) begin
            ram_m[a] = 8'(a * 37 + 11);
            wr_byte(8'(a), ram_m[a]);
        end
    endtask

    task automatic t_direct();
        logic [7:0] d;
        rd_byte(8'h00, d); check("R2", "read 0x00", 32'(d), 32'(ram_m[0]));
        rd_byte(8'h55, d); check("R2", "read 0x55", 32'(d), 32'(ram_m[8'h55]));
        rd_byte(8'h7F, d); check("R2", "read 0x7F", 32'(d), 32'(ram_m[8'h7F]));
        byte_en = 1; byte_we = 1; byte_addr = 8'h33; byte_wdata = 8'hA5;
        cyc(); idle();
        check("R2", "read during write old value", 32'(byte_rdata), 32'(ram_m[8'h33]));
        ram_m[8'h33] = 8'hA5;
        rd_byte(8'h33, d); check("R2", "read after write", 32'(d), 32'hA5);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        for (int b = 0; b < 4; b++) begin
            int n = (b + 5) % 8;
            set_bank(2'(b));
            check("R4", "bank loaded", 32'(bank_q), 32'(b));
            reg_idx = 3'(n); reg_we = 1; reg_wdata = 8'(8'h80 + 16 * b + n);
            cyc(); idle();
            ram_m[8 * b + n] = 8'(8'h80 + 16 * b + n);
            rd_byte(8'(8 * b + n), d);
            check("R3", "reg write lands at 8b+n", 32'(d), 32'(ram_m[8 * b + n]));
            reg_idx = 3'(n);
            cyc();
            check("R3", "reg read in bank", 32'(reg_rdata), 32'(ram_m[8 * b + n]));
            idle();
        end
        bank_we = 1; bank_wdata = 2'd1; reg_idx = 3'd2;
        cyc();
        check("R4", "same-cycle switch uses old bank", 32'(reg_rdata), 32'(ram_m[8 * 3 + 2]));
        bank_we = 0;
        cyc();
        check("R4", "new bank next cycle", 32'(reg_rdata), 32'(ram_m[8 * 1 + 2]));
        idle();
    endtask

    task automatic t_indirect();
        logic [7:0] d;
        logic [7:0] sfr_keep;
        sfr_keep = sfr_mem[8'hC6];
        set_bank(2'd2);
        reg_idx = 3'd0; reg_we = 1; reg_wdata = 8'h45; cyc();
        reg_idx = 3'd1; reg_wdata = 8'hC6; cyc(); idle();
        ram_m[16] = 8'h45; ram_m[17] = 8'hC6;
        byte_en = 1; byte_ind = 1; byte_ptr = 0;
        cyc(); idle();
        check("R5", "indirect read via R0", 32'(byte_rdata), 32'(ram_m[8'h45]));
        byte_en = 1; byte_we = 1; byte_ind = 1; byte_ptr = 1; byte_wdata = 8'h3C;
        #1;
        check("R5", "indirect write keeps side port idle", 32'({sfr_re, sfr_we}), 0);
        cyc(); idle();
        ram_m[8'h46] = 8'h3C;
        rd_byte(8'h46, d);
        check("R5", "indirect via R1 drops pointer bit 7", 32'(d), 32'h3C);
        check("R5", "side register untouched", 32'(sfr_mem[8'hC6]), 32'(sfr_keep));
    endtask

    task automatic t_sfr_byte();
        logic [7:0] d;
        byte_en = 1; byte_we = 1; byte_addr = 8'h90; byte_wdata = 8'h6E;
        #1;
        check("R6", "side address", 32'(sfr_addr), 32'h90);
        check("R6", "side write strobe and data", 32'({sfr_we, sfr_wdata}), 32'h16E);
        cyc(); idle();
        check("R6", "side register written", 32'(sfr_mem[8'h90]), 32'h6E);
        rd_byte(8'h10, d);
        check("R6", "scratchpad alias untouched", 32'(d), 32'(ram_m[8'h10]));
        byte_en = 1; byte_addr = 8'hA8;
        #1;
        check("R6", "side read strobe", 32'({sfr_re, sfr_we}), 32'h2);
        cyc(); idle();
        check("R6", "side read data", 32'(byte_rdata), 32'(sfr_mem[8'hA8]));
    endtask

    task automatic t_bits_ram();
        logic [7:0] d;
        logic       v;
        logic [7:0] list [3];
        list[0] = 8'h00; list[1] = 8'h3B; list[2] = 8'h7F;
        for (int i = 0; i < 3; i++) begin
            int by = 32 + int'(list[i] >> 3);
            int ps = int'(list[i] & 8'h07);
            bit_do(2'd1, list[i], v);
            check("R7", "bit read", 32'(v), 32'(ram_m[by][ps]));
            bit_do(2'd2, list[i], v);
            check("R7", "set returns old bit", 32'(v), 32'(ram_m[by][ps]));
            ram_m[by][ps] = 1'b1;
            rd_byte(8'(by), d);
            check("R8", "set touches one bit", 32'(d), 32'(ram_m[by]));
            bit_do(2'd3, list[i], v);
            check("R8", "clear returns old bit", 32'(v), 1);
            ram_m[by][ps] = 1'b0;
            rd_byte(8'(by), d);
            check("R8", "clear touches one bit", 32'(d), 32'(ram_m[by]));
        end
        wr_byte(8'h2C, 8'h20); ram_m[8'h2C] = 8'h20;
        bit_do(2'd1, 8'h65, v);
        check("R10", "bit sees byte write", 32'(v), 1);
        bit_do(2'd1, 8'h64, v);
        check("R10", "neighbour bit of byte write", 32'(v), 0);
    endtask

    task automatic t_bits_sfr();
        logic [7:0] old;
        logic       v;
        old = sfr_mem[8'hA8];
        bit_op = 2'd2; bit_addr = 8'hAF;
        #1;
        check("R9", "0xAF maps to 0xA8", 32'(sfr_addr), 32'hA8);
        check("R9", "side write data bit 7 set", 32'({sfr_we, sfr_wdata}), 32'({1'b1, old | 8'h80}));
        cyc(); v = bit_rdata; idle();
        check("R9", "old bit 7 returned", 32'(v), 32'(old[7]));
        check("R9", "side register after set", 32'(sfr_mem[8'hA8]), 32'(old | 8'h80));
        old = sfr_mem[8'h80];
        bit_do(2'd3, 8'h81, v);
        check("R9", "clear 0x81 returns old", 32'(v), 32'(old[1]));
        check("R9", "side register after clear", 32'(sfr_mem[8'h80]), 32'(old & 8'hFD));
    endtask

    task automatic t_priority();
        logic [7:0] d;
        logic [7:0] old;
        old = ram_m[8'h20];
        bit_op = 2'd2; bit_addr = 8'h02;
        byte_en = 1; byte_we = 1; byte_addr = 8'h20; byte_wdata = 8'h00;
        cyc(); idle();
        ram_m[8'h20] = old | 8'h04;
        rd_byte(8'h20, d);
        check("R11", "bit op beats byte write", 32'(d), 32'(ram_m[8'h20]));
        set_bank(2'd1);
        byte_en = 1; byte_we = 1; byte_addr = 8'h0B; byte_wdata = 8'h11;
        reg_idx = 3'd3; reg_we = 1; reg_wdata = 8'h22;
        cyc(); idle();
        ram_m[8'h0B] = 8'h11;
        rd_byte(8'h0B, d);
        check("R11", "byte write beats register write", 32'(d), 32'h11);
    endtask

    task automatic t_sfr_owner();
        logic [7:0] o90;
        logic [7:0] o98;
        o90 = sfr_mem[8'h90]; o98 = sfr_mem[8'h98];
        bit_op = 2'd2; bit_addr = 8'h91;
        byte_en = 1; byte_we = 1; byte_addr = 8'h98; byte_wdata = 8'hFF;
        cyc(); idle();
        check("R12", "bit op served on side port", 32'(sfr_mem[8'h90]), 32'(o90 | 8'h02));
        check("R12", "byte side write dropped", 32'(sfr_mem[8'h98]), 32'(o98));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) sfr_mem[i] = 8'(i) ^ 8'hC3;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_direct();
        t_regs();
        t_indirect();
        t_sfr_byte();
        t_bits_ram();
        t_bits_sfr();
        t_priority();
        t_sfr_owner();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule